// File: doc/BRIEF.md
# SDRAM Write-Burst Truncation Sequencer

This block produces the command bus, the DQ output enable and the DQM line for the write side of a single-data-rate SDRAM controller. A front end hands it write requests over a valid/ready handshake. Each request names a bank and a starting column, a fixed burst of 1, 2, 4 or 8 beats or a continuous-page burst, and an auto-precharge flag. The target row is assumed to be open already. The block issues the WRITE command and holds the output enable for one cycle per beat. The front end drives the write data on every cycle in which `dq_oe` is high.

While a burst is running, the front end may pulse `stop_req` to cut it short. A stop of the read kind puts a READ on the bus in the next cycle and drops the output enable. A stop of the precharge kind waits the write-recovery time measured from the last wanted beat, then closes the bank with a PRECHARGE. Between the two it masks data with DQM, and when the clock is fast it also masks on the cycle of the PRECHARGE itself. Per-bank timers raise `bank_busy` while a bank is recovering from a PRECHARGE or from an auto precharge, and the request handshake refuses any write to a busy bank.

Handshake rules: `req_ready` depends on `req_bank` and `stop_req` in the same cycle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The front end must hold a request stable until it is taken, and it must present write data on every cycle that `dq_oe` is high; it cannot stall a burst once the WRITE has gone out. A continuous-page burst ends only through a stop.

Top module: `sdr_wtrunc_seq`

## Requirements
- R1: After reset the command bus carries NOP (`cmd`=3'b111), `dq_oe`, `dqm` and every `bank_busy` bit are low, and `req_ready` is high.
- R2: A request taken at a clock edge puts WRITE (`cmd`=3'b100) on the bus in the next cycle, with `cmd_bank` set to the request bank, `cmd_addr` low bits set to the column and `cmd_addr[10]` set to the auto-precharge flag (always forced to 0 for continuous page). In that cycle `dq_oe` is high and `dqm` is low.
- R3: A fixed burst with `req_blen` code n (0..3) holds `dq_oe` high for exactly 2^n cycles, starting with the WRITE cycle. Every cycle after the WRITE carries NOP, and `dq_oe` is low afterwards.
- R4: `req_ready` is high when the block is idle and the request bank is not busy. It is also high on the last beat of a fixed burst, but only if the request bank is not busy and is not the bank of a burst that uses auto precharge. A stop accepted in the same cycle forces it low. It is low on every other beat and during write recovery. A request taken on the last beat issues its WRITE in the very next cycle.
- R5: A read stop (`stop_req`=1, `stop_rd`=1) seen in a burst cycle k issues READ (`cmd`=3'b101) in cycle k+1. That READ carries the current bank, with `stop_col` in the low address bits and `cmd_addr[10]`=0, and `dq_oe` is low from cycle k+1. A read stop on the last beat of a fixed burst behaves the same way.
- R6: A precharge stop (`stop_rd`=0) seen in burst cycle k issues PRECHARGE (`cmd`=3'b010) to the current bank, with `cmd_addr` all zero, in cycle k+TWR. It places NOP on the bus in between, and `dq_oe` is low from cycle k+1.
- R7: After an accepted precharge stop in cycle k, `dqm` is high in cycles k+1 through k+TWR-1. In the PRECHARGE cycle it equals FAST_CLK.
- R8: A precharge stop during a fixed burst that uses auto precharge is ignored: the burst runs all of its beats with `dqm` low and no extra command.
- R9: A continuous-page burst keeps `dq_oe` high on every cycle until a stop is accepted.
- R10: After a PRECHARGE issued in cycle p, `bank_busy` for that bank is high in cycles p through p+TRP-2. While it is high, `req_ready` is low for requests to that bank.
- R11: When a fixed burst with auto precharge ends with its last beat in cycle L, `bank_busy` for its bank is high in cycles L+1 through L+TWR+TRP-2.
- R12: A stop request while no burst is running has no effect: the bus stays at NOP and `dq_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Write request can be taken this cycle |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Start column |
| req_blen | input | 2 | Burst length code, 2^code beats |
| req_page | input | 1 | Continuous-page burst |
| req_ap | input | 1 | Auto precharge after a fixed burst |
| stop_req | input | 1 | Cut the running burst short |
| stop_rd | input | 1 | 1: cut with READ, 0: cut with PRECHARGE |
| stop_col | input | COL_W | Column for the truncating READ |
| cmd | output | 3 | {RAS#, CAS#, WE#} command code |
| cmd_bank | output | BANK_W | Command bank |
| cmd_addr | output | ADDR_W | Command address |
| dq_oe | output | 1 | Write data driven this cycle |
| dqm | output | 1 | Data mask |
| bank_busy | output | 2**BANK_W | Per-bank precharge wait running |

## Verification
A beat counter that has slipped shows up on the very cycle the burst should end: `dq_oe` is high for one cycle too many or too few, and `req_ready` rises on the wrong beat. A wrong write-recovery count moves the PRECHARGE, and the DQM window with it, by one or more cycles. That is visible within TWR cycles of the stop. A bank timer that is loaded wrongly or not at all shows on `bank_busy` and `req_ready` for that bank from the first cycle after the PRECHARGE or the last auto-precharge beat.

// File: rtl/sdr_wts_pkg.sv
package sdr_wts_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'b111,
    CMD_READ  = 3'b101,
    CMD_WRITE = 3'b100,
    CMD_PRE   = 3'b010
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BURST,
    ST_RECOV
  } seq_st_e;

  localparam int BLEN_CODE_W = 2;
  localparam int BEAT_W      = 3;

  function automatic logic [BEAT_W-1:0] beats_minus_one(input logic [BLEN_CODE_W-1:0] code);
    logic [BEAT_W:0] full;
    full = (BEAT_W+1)'(1) << code;
    return BEAT_W'(full - (BEAT_W+1)'(1));
  endfunction
endpackage

// File: rtl/wts_beat_ctr.sv
module wts_beat_ctr #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (step && cnt != '0) cnt <= cnt - CW'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/wts_rec_timer.sv
module wts_rec_timer #(
  parameter int RW    = 2,
  parameter int LOADV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic fire
);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= RW'(LOADV);
    else if (cnt != '0)  cnt <= cnt - RW'(1);
  end

  // The edge that closes a cycle with count 1 issues the precharge.
  assign fire = (cnt == RW'(1));
endmodule

// File: rtl/wts_bank_guard.sv
module wts_bank_guard #(
  parameter int BANK_W = 2,
  parameter int GW     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld,
  input  logic [BANK_W-1:0]    ld_bank,
  input  logic [GW-1:0]        ld_val,
  output logic [2**BANK_W-1:0] busy
);
  localparam int NBANK = 2**BANK_W;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [GW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n)                             cnt <= '0;
      else if (ld && ld_bank == BANK_W'(g))   cnt <= ld_val;
      else if (cnt != '0)                     cnt <= cnt - GW'(1);
    end
    assign busy[g] = (cnt != '0);
  end
endmodule

// File: rtl/sdr_wtrunc_seq.sv
module sdr_wtrunc_seq
  import sdr_wts_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int COL_W    = 10,
  parameter int ADDR_W   = 13,
  parameter int AP_BIT   = 10,
  parameter int TWR      = 2,
  parameter int TRP      = 3,
  parameter int FAST_CLK = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [COL_W-1:0]     req_col,
  input  logic [1:0]           req_blen,
  input  logic                 req_page,
  input  logic                 req_ap,
  input  logic                 stop_req,
  input  logic                 stop_rd,
  input  logic [COL_W-1:0]     stop_col,
  output logic [2:0]           cmd,
  output logic [BANK_W-1:0]    cmd_bank,
  output logic [ADDR_W-1:0]    cmd_addr,
  output logic                 dq_oe,
  output logic                 dqm,
  output logic [2**BANK_W-1:0] bank_busy
);
  localparam int TWR_C = (TWR < 1) ? 1 : TWR;
  localparam int TRP_C = (TRP < 1) ? 1 : TRP;
  localparam int RW    = $clog2(TWR_C + 1);
  localparam int GW    = $clog2(TWR_C + TRP_C);
  localparam logic MASK_AT_PRE = (FAST_CLK != 0);

  seq_st_e           st;
  sdr_cmd_e          cmd_q;
  logic [BANK_W-1:0] bank_q, cur_bank;
  logic [ADDR_W-1:0] addr_q, wr_addr, rd_addr;
  logic              oe_q, dqm_q, cur_page, cur_ap;
  logic              beat_zero, rec_fire;
  logic              last_beat, stop_ok, stop_rdgo, stop_prgo;
  logic              can_take, take, pre_go, ap_end;
  logic              guard_ld;
  logic [GW-1:0]     guard_val;

  assign last_beat = (st == ST_BURST) && !cur_page && beat_zero;
  assign stop_ok   = (st == ST_BURST) && stop_req && (stop_rd || cur_page || !cur_ap);
  assign stop_rdgo = stop_ok && stop_rd;
  assign stop_prgo = stop_ok && !stop_rd;
  assign can_take  = (st == ST_IDLE) ||
                     (last_beat && !(cur_ap && req_bank == cur_bank));
  assign req_ready = can_take && !bank_busy[req_bank] && !stop_ok;
  assign take      = req_valid && req_ready;
  assign pre_go    = ((st == ST_RECOV) && rec_fire) || (stop_prgo && TWR_C == 1);
  assign ap_end    = last_beat && cur_ap && !stop_rdgo;

  always_comb begin
    wr_addr = '0;
    wr_addr[COL_W-1:0] = req_col;
    wr_addr[AP_BIT]    = req_ap && !req_page;
    rd_addr = '0;
    rd_addr[COL_W-1:0] = stop_col;
  end

  always_comb begin
    guard_ld  = pre_go || ap_end;
    guard_val = pre_go ? GW'(TRP_C - 1) : GW'(TWR_C + TRP_C - 2);
  end

  wts_beat_ctr #(.CW(BEAT_W)) u_beats (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .load_val (beats_minus_one(req_blen)),
    .step     (st == ST_BURST),
    .zero     (beat_zero)
  );

  wts_rec_timer #(.RW(RW), .LOADV(TWR_C - 1)) u_recov (
    .clk   (clk),
    .rst_n (rst_n),
    .start (stop_prgo && TWR_C > 1),
    .fire  (rec_fire)
  );

  wts_bank_guard #(.BANK_W(BANK_W), .GW(GW)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (guard_ld),
    .ld_bank (cur_bank),
    .ld_val  (guard_val),
    .busy    (bank_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cmd_q    <= CMD_NOP;
      bank_q   <= '0;
      addr_q   <= '0;
      oe_q     <= 1'b0;
      dqm_q    <= 1'b0;
      cur_bank <= '0;
      cur_page <= 1'b0;
      cur_ap   <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
      oe_q   <= 1'b0;
      dqm_q  <= 1'b0;
      if (take) begin
        cmd_q    <= CMD_WRITE;
        bank_q   <= req_bank;
        addr_q   <= wr_addr;
        oe_q     <= 1'b1;
        cur_bank <= req_bank;
        cur_page <= req_page;
        cur_ap   <= req_ap && !req_page;
        st       <= ST_BURST;
      end else begin
        unique case (st)
          ST_BURST: begin
            if (stop_rdgo) begin
              cmd_q  <= CMD_READ;
              bank_q <= cur_bank;
              addr_q <= rd_addr;
              st     <= ST_IDLE;
            end else if (stop_prgo) begin
              if (TWR_C == 1) begin
                cmd_q  <= CMD_PRE;
                bank_q <= cur_bank;
                dqm_q  <= MASK_AT_PRE;
                st     <= ST_IDLE;
              end else begin
                dqm_q <= 1'b1;
                st    <= ST_RECOV;
              end
            end else if (last_beat) begin
              st <= ST_IDLE;
            end else begin
              oe_q <= 1'b1;
            end
          end
          ST_RECOV: begin
            if (rec_fire) begin
              cmd_q  <= CMD_PRE;
              bank_q <= cur_bank;
              dqm_q  <= MASK_AT_PRE;
              st     <= ST_IDLE;
            end else begin
              dqm_q <= 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign cmd      = cmd_q;
  assign cmd_bank = bank_q;
  assign cmd_addr = addr_q;
  assign dq_oe    = oe_q;
  assign dqm      = dqm_q;
endmodule

// File: rtl/sdr_wtrunc_seq_chk.sv
module sdr_wtrunc_seq_chk
  import sdr_wts_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int TWR      = 2,
  parameter int TRP      = 3,
  parameter int FAST_CLK = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [BANK_W-1:0]    req_bank,
  input logic [2:0]           cmd,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic                 dq_oe,
  input logic                 dqm,
  input logic [2**BANK_W-1:0] bank_busy
);
  localparam int TWR_C = (TWR < 1) ? 1 : TWR;
  localparam int TRP_C = (TRP < 1) ? 1 : TRP;

  // R2
  legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_NOP || cmd == CMD_READ || cmd == CMD_WRITE || cmd == CMD_PRE);

  // R2
  accept_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> cmd == CMD_WRITE);

  // R2
  write_drives_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_WRITE |-> dq_oe && !dqm);

  // R5
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_READ |-> !dq_oe);

  // R7
  pre_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_PRE |-> (dqm == (FAST_CLK != 0)) && !dq_oe);

  // R10
  accept_free_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |-> !bank_busy[req_bank]);

  if (TWR_C >= 2) begin : g_pre_lead
    // R7
    pre_lead_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_PRE |-> $past(dqm) && !$past(dq_oe));
  end

  if (TRP_C >= 2) begin : g_pre_busy
    // R10
    pre_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_PRE |-> bank_busy[cmd_bank]);
  end
endmodule

bind sdr_wtrunc_seq sdr_wtrunc_seq_chk #(
  .BANK_W(BANK_W), .TWR(TWR), .TRP(TRP), .FAST_CLK(FAST_CLK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bank(req_bank), .cmd(cmd), .cmd_bank(cmd_bank), .dq_oe(dq_oe),
  .dqm(dqm), .bank_busy(bank_busy)
);

// File: tb/sdr_wtrunc_seq_bench.sv
`timescale 1ns/1ps
module sdr_wtrunc_seq_bench;
  localparam int C_NOP = 7, C_RD = 5, C_WR = 4, C_PRE = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [9:0]  req_col = '0;
  logic [1:0]  req_blen = '0;
  logic        req_page = 1'b0;
  logic        req_ap = 1'b0;
  logic        stop_req = 1'b0;
  logic        stop_rd = 1'b0;
  logic [9:0]  stop_col = '0;
  logic [2:0]  cmd;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;
  logic        dq_oe, dqm;
  logic [3:0]  bank_busy;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sdr_wtrunc_seq u_sdr_wtrunc_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col), .req_blen(req_blen),
    .req_page(req_page), .req_ap(req_ap), .stop_req(stop_req),
    .stop_rd(stop_rd), .stop_col(stop_col), .cmd(cmd), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .dq_oe(dq_oe), .dqm(dqm), .bank_busy(bank_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (6) step();
  endtask

  task automatic put_req(input int bank, input int col, input int blen,
                         input bit page, input bit ap);
    req_valid = 1'b1; req_bank = 2'(bank); req_col = 10'(col);
    req_blen = 2'(blen); req_page = page; req_ap = ap;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    #1;
    chk("R1 cmd", cmd, C_NOP);
    chk("R1 dq_oe", dq_oe, 0);
    chk("R1 dqm", dqm, 0);
    chk("R1 busy", bank_busy, 0);
    chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_fixed_write();
    put_req(1, 'h23, 2, 0, 0);
    chk("R4 idle ready", req_ready, 1);
    step(); req_valid = 1'b0; #1;
    chk("R2 cmd", cmd, C_WR);
    chk("R2 bank", cmd_bank, 1);
    chk("R2 addr", cmd_addr, 'h23);
    chk("R2 oe", dq_oe, 1);
    chk("R2 dqm", dqm, 0);
    step(); #1;
    chk("R3 beat2 cmd", cmd, C_NOP);
    chk("R3 beat2 oe", dq_oe, 1);
    chk("R4 mid ready", req_ready, 0);
    step(); step(); #1;
    chk("R3 beat4 oe", dq_oe, 1);
    chk("R4 last ready", req_ready, 1);
    step(); #1;
    chk("R3 end oe", dq_oe, 0);
    chk("R3 end cmd", cmd, C_NOP);
    settle();
  endtask

  task automatic t_back_to_back_ap();
    put_req(0, 3, 1, 0, 0);
    step(); req_valid = 1'b0;
    step();
    put_req(2, 7, 0, 0, 1);
    chk("R4 last beat ready", req_ready, 1);
    step(); req_valid = 1'b0; #1;
    chk("R4 b2b cmd", cmd, C_WR);
    chk("R2 ap bank", cmd_bank, 2);
    chk("R2 ap addr", cmd_addr, 1031);
    chk("R11 same bank ready", req_ready, 0);
    for (int i = 1; i <= 3; i++) begin
      step(); #1;
      chk("R11 busy", bank_busy[2], 1);
    end
    step(); #1;
    chk("R11 busy clear", bank_busy[2], 0);
    settle();
  endtask

  task automatic t_read_trunc();
    put_req(1, 0, 3, 0, 0);
    step(); req_valid = 1'b0;
    step(); step();
    stop_req = 1'b1; stop_rd = 1'b1; stop_col = 'h55;
    step(); stop_req = 1'b0; #1;
    chk("R5 cmd", cmd, C_RD);
    chk("R5 bank", cmd_bank, 1);
    chk("R5 addr", cmd_addr, 'h55);
    chk("R5 oe", dq_oe, 0);
    step(); #1;
    chk("R5 after cmd", cmd, C_NOP);
    chk("R5 after oe", dq_oe, 0);
    settle();
  endtask

  task automatic t_page_pre();
    put_req(3, 0, 0, 1, 1);
    step(); req_valid = 1'b0; #1;
    chk("R2 page ap bit", cmd_addr, 0);
    for (int i = 0; i < 4; i++) begin
      step(); #1;
      chk("R9 page oe", dq_oe, 1);
    end
    stop_req = 1'b1; stop_rd = 1'b0;
    step(); stop_req = 1'b0; #1;
    chk("R6 gap cmd", cmd, C_NOP);
    chk("R6 gap oe", dq_oe, 0);
    chk("R7 gap dqm", dqm, 1);
    step();
    req_bank = 2'd3; #1;
    chk("R6 pre cmd", cmd, C_PRE);
    chk("R6 pre bank", cmd_bank, 3);
    chk("R6 pre addr", cmd_addr, 0);
    chk("R7 pre dqm", dqm, 1);
    chk("R10 busy p", bank_busy[3], 1);
    chk("R10 ready blocked", req_ready, 0);
    step(); #1;
    chk("R10 busy p+1", bank_busy[3], 1);
    step(); #1;
    chk("R10 busy clear", bank_busy[3], 0);
    chk("R10 ready back", req_ready, 1);
    settle();
  endtask

  task automatic t_pre_on_ap();
    put_req(0, 0, 2, 0, 1);
    step(); req_valid = 1'b0;
    step();
    stop_req = 1'b1; stop_rd = 1'b0;
    step(); stop_req = 1'b0; #1;
    chk("R8 oe", dq_oe, 1);
    chk("R8 cmd", cmd, C_NOP);
    chk("R8 dqm", dqm, 0);
    step(); #1;
    chk("R8 last oe", dq_oe, 1);
    step(); #1;
    chk("R8 end oe", dq_oe, 0);
    chk("R8 end cmd", cmd, C_NOP);
    settle();
  endtask

  task automatic t_idle_stop();
    stop_req = 1'b1; stop_rd = 1'b1;
    step(); stop_rd = 1'b0;
    step(); stop_req = 1'b0; #1;
    chk("R12 cmd", cmd, C_NOP);
    chk("R12 oe", dq_oe, 0);
    step(); #1;
    chk("R12 cmd2", cmd, C_NOP);
    chk("R12 dqm", dqm, 0);
    settle();
  endtask

  task automatic t_read_after_end();
    put_req(2, 0, 0, 0, 0);
    step(); req_valid = 1'b0;
    stop_req = 1'b1; stop_rd = 1'b1; stop_col = 9;
    step(); stop_req = 1'b0; #1;
    chk("R5 end cmd", cmd, C_RD);
    chk("R5 end addr", cmd_addr, 9);
    chk("R5 end bank", cmd_bank, 2);
    settle();
  endtask

  task automatic t_stop_blocks_req();
    put_req(1, 0, 1, 0, 0);
    step(); req_valid = 1'b0;
    step();
    stop_req = 1'b1; stop_rd = 1'b1;
    put_req(0, 4, 0, 0, 0);
    chk("R4 stop blocks", req_ready, 0);
    step(); req_valid = 1'b0; stop_req = 1'b0; #1;
    chk("R5 stop wins", cmd, C_RD);
    settle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_fixed_write();
    t_back_to_back_ap();
    t_read_trunc();
    t_page_pre();
    t_pre_on_ap();
    t_idle_stop();
    t_read_after_end();
    t_stop_blocks_req();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule